// File: doc/BRIEF.md
# Serial Fuzzy Rule Accumulator for Lens Focus Control

This block turns fuzzy membership degrees into a signed lens-motor command. Upstream logic supplies, as unsigned 8-bit degrees (0 means no match, 255 means full match), the membership of the current sharpness change in four sets (zero, small, medium, big) and the membership of the average grey level in five sets (negative big, negative small, zero, positive small, positive big). A fixed base of six rules pairs one sharpness set with one grey-level set. Each rule is scaled by a signed weight that software loads into a small register bank.

A start pulse latches both membership vectors into staging registers. The block then walks the six rules, one rule per clock cycle. For each rule, multiplexers pick the two degrees and the weight. All three are converted to an internal floating-point form, multiplied together in a single three-operand multiplier, and added to a floating-point accumulator by a single adder. After the last rule, the accumulated sum is scaled down, truncated toward zero, saturated to a signed 10-bit value and registered as the motor command. A one-cycle done pulse marks the update.

The internal significand is wide enough that every product and every partial sum in the six-rule evaluation is exact. The motor command therefore equals the integer formula given in R3, R6 and R7.

Top module: `afr_rule_accum`

## Requirements
- R1: While reset is asserted, and after it is released, motor_cmd is 0 and done is 0. All six weights reset to 0, so an evaluation run before any weight write yields 0 for any memberships.
- R2: A start sampled high while the block is idle begins an evaluation. On the 7th rising edge after the edge that sampled start, motor_cmd takes its new value and done goes high for exactly one cycle.
- R3: The rule table is fixed. Sharpness sets are bytes 0..3 of di_mu (zero, small, medium, big). Grey-level sets are bytes 0..4 of ag_mu (negative big, negative small, zero, positive small, positive big). The rules 0..5, each written as (sharpness, grey), are (0,2), (1,1), (1,3), (2,0), (2,4), (3,2). The raw sum is S = sum over r of di_byte * ag_byte * weight_r.
- R4: A weight is a 10-bit two's-complement value. It is written to register w_addr (0..5) on a rising edge where w_we is high.
- R5: A write with w_addr equal to 6 or 7 changes no weight.
- R6: motor_cmd = S / 65536, truncated toward zero.
- R7: A result above 511 gives 511, and a result below -512 gives -512.
- R8: A start that arrives while an evaluation is in progress is ignored. It neither restarts the evaluation nor produces an extra done pulse.
- R9: Memberships are sampled only on the start edge. Changes to di_mu or ag_mu during an evaluation have no effect on the result.
- R10: Rule k reads its weight on the (k+1)th edge after the start edge. A write to that weight sampled on that same edge is not seen by the evaluation in progress, while a write sampled on an earlier edge is seen.
- R11: motor_cmd changes only on the edge that raises done. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an evaluation (sampled when idle) |
| di_mu | input | 32 | Four sharpness-change membership degrees, byte per set |
| ag_mu | input | 40 | Five grey-level membership degrees, byte per set |
| w_we | input | 1 | Weight write enable |
| w_addr | input | 3 | Weight register index |
| w_data | input | 10 | Signed weight value |
| motor_cmd | output | 10 | Signed registered motor command |
| done | output | 1 | One-cycle pulse when motor_cmd updates |

## Verification
Two functions can collide in the same cycle: a weight write landing on the very edge where the serial sequencer consumes that weight, and a fresh start arriving while the sequencer is mid-run. The bench times a write to weight 2 exactly onto the edge that evaluates rule 2, and expects the old weight in the result and the new one in the next run. It then moves a write to weight 3 one edge ahead of rule 3 and expects the new value at once. A second start is raised in the middle of a run together with altered memberships. The bench judges it by an unchanged result, an unchanged latency and the absence of any further done pulse.

// File: rtl/afr_pkg.sv
package afr_pkg;

  localparam int SIG_W   = 28;
  localparam int EXP_W   = 8;
  localparam int NRULES  = 6;
  localparam int DI_SETS = 4;
  localparam int AG_SETS = 5;

  // value = (-1)^neg * sig * 2^exp ; sig == 0 encodes zero
  typedef struct packed {
    logic                    neg;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } fp_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } phase_e;

  // sharpness-set index used by rule r
  function automatic int di_sel(int r);
    case (r)
      0:       return 0;
      1, 2:    return 1;
      3, 4:    return 2;
      default: return 3;
    endcase
  endfunction

  // grey-level-set index used by rule r
  function automatic int ag_sel(int r);
    case (r)
      0:       return 2;
      1:       return 1;
      2:       return 3;
      3:       return 0;
      4:       return 4;
      default: return 2;
    endcase
  endfunction

  // normalise a magnitude so that the significand MSB is set
  function automatic fp_t fp_norm(logic neg, logic [SIG_W-1:0] mag, int e);
    fp_t r;
    int  top;
    int  sh;
    r   = '0;
    top = 0;
    for (int i = 0; i < SIG_W; i++) begin
      if (mag[i]) top = i;
    end
    if (mag != '0) begin
      sh    = SIG_W - 1 - top;
      r.neg = neg;
      r.sig = mag << sh;
      r.exp = EXP_W'(e - sh);
    end
    return r;
  endfunction

endpackage

// File: rtl/afr_rst_sync.sv
module afr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/afr_weight_bank.sv
module afr_weight_bank #(
  parameter int N   = 6,
  parameter int W_W = 10,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_sn,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [W_W-1:0] data,
  output logic [N*W_W-1:0] wt_flat
);
  for (genvar i = 0; i < N; i++) begin : g_wreg
    logic           hit;
    logic [W_W-1:0] wq;

    assign hit = we && (int'(addr) == i);

    always_ff @(posedge clk or negedge rst_sn) begin
      if (!rst_sn)  wq <= '0;
      else if (hit) wq <= data;
    end

    assign wt_flat[i*W_W +: W_W] = wq;
  end
endmodule

// File: rtl/afr_fp_mul3.sv
module afr_fp_mul3
  import afr_pkg::*;
(
  input  fp_t a,
  input  fp_t b,
  input  fp_t c,
  output fp_t y
);
  localparam int PW = 3 * SIG_W;

  logic [PW-1:0] prod;
  int            top;

  always_comb begin
    prod = PW'(a.sig) * PW'(b.sig) * PW'(c.sig);
    top  = SIG_W - 1;
    for (int i = SIG_W - 1; i < PW; i++) begin
      if (prod[i]) top = i;
    end
    y = '0;
    if (a.sig != '0 && b.sig != '0 && c.sig != '0) begin
      y.neg = a.neg ^ b.neg ^ c.neg;
      y.sig = SIG_W'(prod >> (top - SIG_W + 1));
      y.exp = EXP_W'(int'(a.exp) + int'(b.exp) + int'(c.exp) + top - (SIG_W - 1));
    end
  end
endmodule

// File: rtl/afr_fp_add.sv
module afr_fp_add
  import afr_pkg::*;
(
  input  fp_t a,
  input  fp_t b,
  output fp_t y
);
  logic             a_big;
  fp_t              big;
  fp_t              sml;
  int               dexp;
  logic [SIG_W-1:0] aligned;
  logic [SIG_W:0]   sum;
  logic [SIG_W-1:0] dif;

  always_comb begin
    a_big   = (a.exp > b.exp) || ((a.exp == b.exp) && (a.sig >= b.sig));
    big     = a_big ? a : b;
    sml     = a_big ? b : a;
    dexp    = int'(big.exp) - int'(sml.exp);
    aligned = (dexp >= SIG_W) ? '0 : (sml.sig >> dexp);
    sum     = {1'b0, big.sig} + {1'b0, aligned};
    dif     = big.sig - aligned;
    y       = '0;
    if (a.sig == '0) begin
      y = b;
    end else if (b.sig == '0) begin
      y = a;
    end else if (big.neg == sml.neg) begin
      y.neg = big.neg;
      if (sum[SIG_W]) begin
        y.sig = sum[SIG_W:1];
        y.exp = big.exp + EXP_W'(1);
      end else begin
        y.sig = sum[SIG_W-1:0];
        y.exp = big.exp;
      end
    end else begin
      y = fp_norm(big.neg, dif, int'(big.exp));
    end
  end
endmodule

// File: rtl/afr_rule_accum.sv
module afr_rule_accum
  import afr_pkg::*;
#(
  parameter int MU_W      = 8,
  parameter int W_W       = 10,
  parameter int OUT_W     = 10,
  parameter int OUT_SHIFT = 16,
  parameter int AW        = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [DI_SETS*MU_W-1:0]   di_mu,
  input  logic [AG_SETS*MU_W-1:0]   ag_mu,
  input  logic                      w_we,
  input  logic [AW-1:0]             w_addr,
  input  logic [W_W-1:0]            w_data,
  output logic [OUT_W-1:0]          motor_cmd,
  output logic                      done
);
  localparam int IDX_W = $clog2(NRULES);
  localparam logic [SIG_W-1:0] POS_LIM = SIG_W'((1 << (OUT_W - 1)) - 1);
  localparam logic [SIG_W-1:0] NEG_LIM = SIG_W'(1 << (OUT_W - 1));

  logic rst_sn;

  phase_e                    phase_q, phase_d;
  logic [IDX_W-1:0]          idx_q, idx_d;
  logic [DI_SETS*MU_W-1:0]   di_stg_q, di_stg_d;
  logic [AG_SETS*MU_W-1:0]   ag_stg_q, ag_stg_d;
  fp_t                       acc_q, acc_d;
  logic [OUT_W-1:0]          motor_q, motor_d;
  logic                      done_q, done_d;

  logic [NRULES*W_W-1:0]     wt_flat;
  logic [MU_W-1:0]           rule_da [NRULES];
  logic [MU_W-1:0]           rule_ga [NRULES];
  logic [W_W-1:0]            rule_w  [NRULES];
  logic [MU_W-1:0]           sel_da, sel_ga;
  logic [W_W-1:0]            sel_w;
  logic [W_W:0]              wmag;
  fp_t                       fa, fb, fw, prod, acc_sum;

  logic [SIG_W-1:0]          cmag;
  logic [SIG_W-1:0]          cneg;
  int                        csh;
  logic [OUT_W-1:0]          conv;

  afr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  afr_weight_bank #(.N(NRULES), .W_W(W_W), .AW(AW)) u_wbank (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .we      (w_we),
    .addr    (w_addr),
    .data    (w_data),
    .wt_flat (wt_flat)
  );

  // per-rule operand wiring from the fixed rule table
  for (genvar r = 0; r < NRULES; r++) begin : g_rule
    assign rule_da[r] = di_stg_q[di_sel(r)*MU_W +: MU_W];
    assign rule_ga[r] = ag_stg_q[ag_sel(r)*MU_W +: MU_W];
    assign rule_w[r]  = wt_flat[r*W_W +: W_W];
  end

  // rule selection muxes and integer-to-float conversion
  always_comb begin
    sel_da = '0;
    sel_ga = '0;
    sel_w  = '0;
    if (int'(idx_q) < NRULES) begin
      sel_da = rule_da[idx_q];
      sel_ga = rule_ga[idx_q];
      sel_w  = rule_w[idx_q];
    end
    wmag = sel_w[W_W-1] ? (~{1'b1, sel_w} + 1'b1) : {1'b0, sel_w};
    fa   = fp_norm(1'b0, SIG_W'(sel_da), 0);
    fb   = fp_norm(1'b0, SIG_W'(sel_ga), 0);
    fw   = fp_norm(sel_w[W_W-1], SIG_W'(wmag), 0);
  end

  afr_fp_mul3 u_mul (
    .a (fa),
    .b (fb),
    .c (fw),
    .y (prod)
  );

  afr_fp_add u_add (
    .a (acc_q),
    .b (prod),
    .y (acc_sum)
  );

  // float to saturated signed integer, truncating toward zero
  always_comb begin
    csh  = int'(acc_q.exp) - OUT_SHIFT;
    cmag = '0;
    if (acc_q.sig == '0)      cmag = '0;
    else if (csh >= 0)        cmag = {SIG_W{1'b1}};
    else if (-csh >= SIG_W)   cmag = '0;
    else                      cmag = acc_q.sig >> (-csh);
    cneg = '0 - cmag;
    if (!acc_q.neg) begin
      conv = (cmag > POS_LIM) ? POS_LIM[OUT_W-1:0] : cmag[OUT_W-1:0];
    end else begin
      conv = (cmag >= NEG_LIM) ? NEG_LIM[OUT_W-1:0] : cneg[OUT_W-1:0];
    end
  end

  // sequencer next state
  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    di_stg_d = di_stg_q;
    ag_stg_d = ag_stg_q;
    acc_d    = acc_q;
    motor_d  = motor_q;
    done_d   = 1'b0;
    case (phase_q)
      ST_IDLE: begin
        if (start) begin
          phase_d  = ST_RUN;
          idx_d    = '0;
          acc_d    = '0;
          di_stg_d = di_mu;
          ag_stg_d = ag_mu;
        end
      end
      ST_RUN: begin
        acc_d = acc_sum;
        if (int'(idx_q) == NRULES - 1) phase_d = ST_FIN;
        else                           idx_d   = idx_q + 1'b1;
      end
      ST_FIN: begin
        motor_d = conv;
        done_d  = 1'b1;
        phase_d = ST_IDLE;
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q  <= ST_IDLE;
      idx_q    <= '0;
      di_stg_q <= '0;
      ag_stg_q <= '0;
      acc_q    <= '0;
      motor_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      idx_q    <= idx_d;
      di_stg_q <= di_stg_d;
      ag_stg_q <= ag_stg_d;
      acc_q    <= acc_d;
      motor_q  <= motor_d;
      done_q   <= done_d;
    end
  end

  assign motor_cmd = motor_q;
  assign done      = done_q;
endmodule

// File: rtl/afr_rule_accum_chk.sv
module afr_rule_accum_chk
  import afr_pkg::*;
#(
  parameter int W_W   = 10,
  parameter int OUT_W = 10,
  parameter int AW    = 3,
  parameter int IDX_W = 3
) (
  input logic                  clk,
  input logic                  rst_sn,
  input logic                  start,
  input logic                  w_we,
  input logic [AW-1:0]         w_addr,
  input logic                  done,
  input logic [OUT_W-1:0]      motor_cmd,
  input phase_e                phase_q,
  input logic [IDX_W-1:0]      idx_q,
  input fp_t                   acc_q,
  input logic [NRULES*W_W-1:0] wt_flat
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  assert_acc_clear_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == ST_IDLE && start) |=> (acc_q.sig == '0));

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == ST_RUN) |-> (int'(idx_q) < NRULES));

  assert_bad_addr_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (w_we && int'(w_addr) >= NRULES) |=> $stable(wt_flat));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == ST_RUN && start) |=> !(phase_q == ST_RUN && idx_q == '0));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    !done |-> $stable(motor_cmd));
endmodule

bind afr_rule_accum afr_rule_accum_chk #(
  .W_W(W_W), .OUT_W(OUT_W), .AW(AW), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .start     (start),
  .w_we      (w_we),
  .w_addr    (w_addr),
  .done      (done),
  .motor_cmd (motor_cmd),
  .phase_q   (phase_q),
  .idx_q     (idx_q),
  .acc_q     (acc_q),
  .wt_flat   (wt_flat)
);

// File: tb/test_afr_rule_accum.sv
module test_afr_rule_accum;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 8;  // negedges after the start-driving negedge

  typedef struct packed {
    logic [31:0] di;
    logic [39:0] ag;
    logic [59:0] w;   // w5..w0, w0 in low bits
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{di: 32'hFFFFFFFF, ag: 40'hFFFFFFFFFF,
      w: {10'd100, 10'd100, 10'd100, 10'd100, 10'd100, 10'd100}},
    '{di: 32'h000000FF, ag: 40'h0000FF0000,
      w: {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd64}},
    '{di: 32'h000000FF, ag: 40'h0000FF0000,
      w: {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'h3C0}},
    '{di: 32'h4080C020, ag: 40'h105090D0F0,
      w: {10'd300, 10'h3F6, 10'd77, 10'h380, 10'd20, 10'd45}},
    '{di: 32'hFFFFFFFF, ag: 40'hFFFFFFFFFF,
      w: {10'h200, 10'h200, 10'h200, 10'h200, 10'h200, 10'h200}},
    '{di: 32'hFFFFFFFF, ag: 40'hFFFFFFFFFF,
      w: {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0}},
    '{di: 32'h80808080, ag: 40'h8080808080,
      w: {10'd1, 10'h3FF, 10'd0, 10'd50, 10'h338, 10'd200}}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] di_mu;
  logic [39:0] ag_mu;
  logic        w_we;
  logic [2:0]  w_addr;
  logic [9:0]  w_data;
  logic [9:0]  motor_cmd;
  logic        done;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  afr_rule_accum i_afr_rule_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .di_mu     (di_mu),
    .ag_mu     (ag_mu),
    .w_we      (w_we),
    .w_addr    (w_addr),
    .w_data    (w_data),
    .motor_cmd (motor_cmd),
    .done      (done)
  );

  function automatic int tb_di(int r);
    int t [6] = '{0, 1, 1, 2, 2, 3};
    return t[r];
  endfunction

  function automatic int tb_ag(int r);
    int t [6] = '{2, 1, 3, 0, 4, 2};
    return t[r];
  endfunction

  // model of R3, R6, R7
  function automatic int model(logic [31:0] di, logic [39:0] ag, logic [59:0] w);
    longint s = 0;
    longint q;
    for (int r = 0; r < 6; r++) begin
      longint a  = longint'(di[tb_di(r)*8 +: 8]);
      longint g  = longint'(ag[tb_ag(r)*8 +: 8]);
      longint wv = longint'($signed(w[r*10 +: 10]));
      s += a * g * wv;
    end
    q = (s < 0) ? -((-s) / 65536) : (s / 65536);
    if (q > 511)  q = 511;
    if (q < -512) q = -512;
    return int'(q);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [9:0] d);
    @(negedge clk);
    w_we   = 1'b1;
    w_addr = 3'(a);
    w_data = d;
    @(negedge clk);
    w_we   = 1'b0;
  endtask

  task automatic load_w(logic [59:0] w);
    for (int r = 0; r < 6; r++) wr(r, w[r*10 +: 10]);
  endtask

  // start a run; optional weight write and re-start at given negedge counts
  task automatic run(int wr_at, int wa, logic [9:0] wd, int rs_at,
                     output int lat, output int val, output bit pulse_ok);
    @(negedge clk);
    start = 1'b1;
    lat   = 0;
    do begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      w_we  = (lat == wr_at);
      if (lat == wr_at) begin
        w_addr = 3'(wa);
        w_data = wd;
      end
      if (lat == rs_at) begin
        start = 1'b1;
        di_mu = '0;
        ag_mu = '0;
      end
    end while (!done && lat < 30);
    w_we  = 1'b0;
    start = 1'b0;
    val   = int'($signed(motor_cmd));
    @(negedge clk);
    pulse_ok = !done;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    int  lat, val, ex;
    bit  pok;
    rst_n = 1'b0;
    start = 1'b0;
    di_mu = '0;
    ag_mu = '0;
    w_we  = 1'b0;
    w_addr = '0;
    w_data = '0;
    repeat (3) @(negedge clk);
    check(motor_cmd == 10'd0 && done == 1'b0, "R1 in reset", int'(motor_cmd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(motor_cmd == 10'd0 && done == 1'b0, "R1 after release", int'(motor_cmd), 0);

    // R1: weights reset to zero
    di_mu = '1;
    ag_mu = '1;
    run(0, 0, '0, 0, lat, val, pok);
    check(val == 0, "R1 zero weights", val, 0);

    // vector table (R2 R3 R4 R6 R7)
    foreach (VECS[i]) begin
      load_w(VECS[i].w);
      di_mu = VECS[i].di;
      ag_mu = VECS[i].ag;
      ex = model(VECS[i].di, VECS[i].ag, VECS[i].w);
      run(0, 0, '0, 0, lat, val, pok);
      check(val == ex, "R3 vector result", val, ex);
      check(lat == LAT && pok, "R2 latency and pulse", lat, LAT);
    end

    // R7 explicit ends, R6 truncation toward zero
    load_w(VECS[0].w); di_mu = VECS[0].di; ag_mu = VECS[0].ag;
    run(0, 0, '0, 0, lat, val, pok);
    check(val == 511, "R7 positive saturation", val, 511);
    load_w(VECS[4].w); di_mu = VECS[4].di; ag_mu = VECS[4].ag;
    run(0, 0, '0, 0, lat, val, pok);
    check(val == -512, "R7 negative saturation", val, -512);
    load_w(VECS[2].w); di_mu = VECS[2].di; ag_mu = VECS[2].ag;
    run(0, 0, '0, 0, lat, val, pok);
    check(val == -63, "R6 truncate negative", val, -63);

    // R5: out-of-range addresses
    load_w({6{10'd10}});
    wr(6, 10'h200);
    wr(7, 10'h200);
    di_mu = '1;
    ag_mu = '1;
    run(0, 0, '0, 0, lat, val, pok);
    check(val == 59, "R5 addr 6/7 ignored", val, 59);

    // R8 R9: start and new memberships mid-run
    run(0, 0, '0, 3, lat, val, pok);
    check(val == 59, "R9 memberships latched", val, 59);
    check(lat == LAT, "R8 no restart", lat, LAT);
    ex = 0;
    repeat (12) begin
      @(negedge clk);
      if (done) ex++;
    end
    check(ex == 0, "R8 no extra done", ex, 0);

    // R10: write lands on the edge that reads weight 2 -> old value
    di_mu = '1;
    ag_mu = '1;
    run(3, 2, 10'd100, 0, lat, val, pok);
    check(val == 59, "R10 same-edge write unseen", val, 59);
    run(0, 0, '0, 0, lat, val, pok);
    check(val == 148, "R10 write seen next run", val, 148);
    // write to weight 3 one edge before rule 3 reads it -> new value
    run(3, 3, 10'h39C, 0, lat, val, pok);
    check(val == 39, "R10 earlier write seen", val, 39);

    // R11: hold between runs
    di_mu = '0;
    wr(0, 10'h200);
    repeat (5) @(negedge clk);
    check(int'($signed(motor_cmd)) == 39, "R11 hold", int'($signed(motor_cmd)), 39);

    // R1: reset in the middle of a run
    di_mu = '1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(motor_cmd == 10'd0 && done == 1'b0, "R1 mid-run reset", int'(motor_cmd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(0, 0, '0, 0, lat, val, pok);
    check(val == 0, "R1 weights cleared", val, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule